// File: doc/BRIEF.md
# Event-Driven State Timer

This block is a timer/counter in which every output change, capture and counter restart is caused by a programmable event rather than by fixed wiring from a compare to a pin. Each event looks at its own compare register, at one selected input pin with a chosen edge or level test, and at a small two-state machine. The event may fire only in the states its mask allows. When an event fires it can set or clear outputs, restart the counter, copy the counter into a capture register, and move the state machine. A single rule decides what happens when one output is both set and cleared in the same cycle.

The counter is either one 32-bit count or two independent 16-bit halves. In the split arrangement each event compares against, and restarts, the half it selects. Software sets up everything through a word-wide register port with a write strobe and a combinational read. The port also gives back the running count, the state, the capture registers and a sticky flag per event.

Top module: `evt_state_timer`

## Requirements
- R1: While `rstN` is low and after it rises, the outputs, the count, the state, the event flags and the capture registers read 0.
- R2: CTRL (address 0x00) bit 0 is the run bit. The count, read at address 0x03, advances by one on each clock while run is 1 and holds while run is 0. Events fire only while run is 1.
- R3: Setting event-config bit 8 makes the event a limit event. On the clock after the cycle in which it fires, the count (or its selected half in split mode) becomes 0 instead of advancing.
- R4: Output o has a config register at 0x10+o. Bits [7:0] are a set mask and bits [15:8] are a clear mask, one bit per event. A set-only or clear-only hit drives the output to 1 or 0 on the clock after the firing cycle.
- R5: Output config bits [17:16] decide a same-cycle set-and-clear hit: 0 keeps the output, 1 sets it, 2 clears it, 3 toggles it.
- R6: Event i has a config register at 0x08+i, and bits [3:2] choose how it fires. The value 0 fires on a compare match alone and 1 on the input test alone. The value 2 fires on either, and 3 only when both hold in the same cycle. The compare value is at 0x04+i.
- R7: Event-config bits [1:0] list the states (bit s for state s) in which the event may fire. Bit 9 makes a firing event load the state (read or written at 0x01) with bit 10 on the next clock. The lowest-index firing event wins.
- R8: With event-config bit 11 set, a firing event copies the count of that same cycle into the capture register chosen by bits [13:12]. Capture register c is read at 0x14+c.
- R9: CTRL bit 1 selects split mode, in which the count holds two 16-bit halves. Event-config bit 14 picks the high half (1) or the low half (0) for both the compare and the limit. The other half is unaffected.
- R10: The event flags (0x02) set bit i when event i fires. Writing 1 to a flag bit clears it.
- R11: Event-config bits [5:4] choose the input pin. Bits [7:6] choose its test: 0 rising edge, 1 falling edge, 2 either edge, 3 high level. An edge is measured against the pin's value on the previous clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address for reads and writes |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Combinational read data for `regAddr` |
| timerIn | input | 2 | Event input pins |
| timerOut | output | 2 | Event-driven outputs |

## Verification
An event is judged in the same cycle that its compare and input conditions hold. The outputs, the state, the flags and the count restart all show the result one clock later, and the capture register takes the count of the firing cycle at that same clock. Reads are combinational, so the count seen at a given moment is the value that the event logic sees in that cycle. The bench drives inputs and reads registers at the falling edge. It triggers on a count it has just read, or raises a pin for one cycle, and then checks the result exactly one falling edge later. In the split case it also checks one edge after that, where the high-half match takes effect.

// File: rtl/sct_pkg.sv
package sct_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 5;
  localparam int MAX_CAP = 2;

  localparam logic [ADDR_W-1:0] A_CTRL   = 5'h00;
  localparam logic [ADDR_W-1:0] A_STATE  = 5'h01;
  localparam logic [ADDR_W-1:0] A_FLAGS  = 5'h02;
  localparam logic [ADDR_W-1:0] A_COUNT  = 5'h03;
  localparam logic [ADDR_W-1:0] A_MATCH  = 5'h04;
  localparam logic [ADDR_W-1:0] A_EVCFG  = 5'h08;
  localparam logic [ADDR_W-1:0] A_OUTCFG = 5'h10;
  localparam logic [ADDR_W-1:0] A_CAP    = 5'h14;

  typedef enum logic [1:0] {CMB_MATCH, CMB_EDGE, CMB_OR, CMB_AND} combine_e;
  typedef enum logic [1:0] {EDG_RISE, EDG_FALL, EDG_BOTH, EDG_HIGH} edge_e;
  typedef enum logic [1:0] {CF_HOLD, CF_SET, CF_CLEAR, CF_TOGGLE} conflict_e;

  // event configuration word, bit 14 down to bit 0
  typedef struct packed {
    logic       halfSel;
    logic [1:0] capSel;
    logic       capEn;
    logic       goState;
    logic       goEn;
    logic       limit;
    edge_e      edgeSel;
    logic [1:0] inSel;
    combine_e   combine;
    logic [1:0] stateMask;
  } ev_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               countEn;
    logic               split;
    logic               limitLo;
    logic               limitHi;
    logic [MAX_CAP-1:0] capLoad;
  } strobe_t;
endpackage

// File: rtl/sct_datapath.sv
module sct_datapath
  import sct_pkg::*;
#(
  parameter int NUM_EV  = 4,
  parameter int NUM_CAP = 2,
  parameter int CNT_W   = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic [CNT_W-1:0] matchVal [NUM_EV],
  input  logic [NUM_EV-1:0] halfSel,
  output logic [NUM_EV-1:0] matchHit,
  output logic [CNT_W-1:0] cntVal,
  output logic [CNT_W-1:0] capVal [NUM_CAP]
);
  localparam int HALF_W = CNT_W / 2;

  logic [HALF_W-1:0] cntLo, cntHi;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntLo <= '0;
      cntHi <= '0;
    end else if (!strobe.split) begin
      if (strobe.limitLo || strobe.limitHi) {cntHi, cntLo} <= '0;
      else if (strobe.countEn) {cntHi, cntLo} <= {cntHi, cntLo} + CNT_W'(1);
    end else begin
      if (strobe.limitLo) cntLo <= '0;
      else if (strobe.countEn) cntLo <= cntLo + HALF_W'(1);
      if (strobe.limitHi) cntHi <= '0;
      else if (strobe.countEn) cntHi <= cntHi + HALF_W'(1);
    end
  end

  assign cntVal = {cntHi, cntLo};

  for (genvar i = 0; i < NUM_EV; i++) begin : g_cmp
    assign matchHit[i] = strobe.split
      ? ((halfSel[i] ? cntHi : cntLo) == matchVal[i][HALF_W-1:0])
      : (cntVal == matchVal[i]);
  end

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_cap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) capVal[c] <= '0;
      else if (strobe.capLoad[c]) capVal[c] <= cntVal;
    end
  end
endmodule

// File: rtl/sct_control.sv
module sct_control
  import sct_pkg::*;
#(
  parameter int NUM_EV  = 4,
  parameter int NUM_OUT = 2,
  parameter int NUM_CAP = 2,
  parameter int NUM_IN  = 2,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic [NUM_IN-1:0] inPins,
  input  logic [NUM_EV-1:0] matchHit,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic [CNT_W-1:0]  capVal [NUM_CAP],
  output logic [CNT_W-1:0]  matchVal [NUM_EV],
  output logic [NUM_EV-1:0] halfSel,
  output strobe_t           strobe,
  output logic [NUM_EV-1:0] evFire,
  output logic [NUM_OUT-1:0] outPins
);
  localparam int IN_SEL_W = (NUM_IN > 1) ? $clog2(NUM_IN) : 1;

  logic run, split, state;
  logic [NUM_EV-1:0] flags, flagClr;
  ev_cfg_t evCfg [NUM_EV];
  logic [NUM_EV-1:0] setMask [NUM_OUT];
  logic [NUM_EV-1:0] clrMask [NUM_OUT];
  conflict_e confl [NUM_OUT];
  logic [NUM_IN-1:0] inPrev;
  logic [NUM_OUT-1:0] setHit, clrHit, outNext;
  logic goAny, goTarget;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      run   <= 1'b0;
      split <= 1'b0;
      for (int i = 0; i < NUM_EV; i++) begin
        matchVal[i] <= '0;
        evCfg[i]    <= '0;
      end
      for (int o = 0; o < NUM_OUT; o++) begin
        setMask[o] <= '0;
        clrMask[o] <= '0;
        confl[o]   <= CF_HOLD;
      end
    end else if (regWe) begin
      if (regAddr == A_CTRL) begin
        run   <= regWdata[0];
        split <= regWdata[1];
      end
      for (int i = 0; i < NUM_EV; i++) begin
        if (regAddr == A_MATCH + ADDR_W'(i)) matchVal[i] <= regWdata[CNT_W-1:0];
        if (regAddr == A_EVCFG + ADDR_W'(i)) evCfg[i] <= ev_cfg_t'(regWdata[14:0]);
      end
      for (int o = 0; o < NUM_OUT; o++) begin
        if (regAddr == A_OUTCFG + ADDR_W'(o)) begin
          setMask[o] <= regWdata[NUM_EV-1:0];
          clrMask[o] <= regWdata[8 +: NUM_EV];
          confl[o]   <= conflict_e'(regWdata[17:16]);
        end
      end
    end
  end

  // event evaluation
  always_comb begin
    logic curIn, prevIn, edgeOk, hit;
    for (int i = 0; i < NUM_EV; i++) begin
      curIn  = inPins[evCfg[i].inSel[IN_SEL_W-1:0]];
      prevIn = inPrev[evCfg[i].inSel[IN_SEL_W-1:0]];
      unique case (evCfg[i].edgeSel)
        EDG_RISE: edgeOk = curIn & ~prevIn;
        EDG_FALL: edgeOk = ~curIn & prevIn;
        EDG_BOTH: edgeOk = curIn ^ prevIn;
        default:  edgeOk = curIn;
      endcase
      unique case (evCfg[i].combine)
        CMB_MATCH: hit = matchHit[i];
        CMB_EDGE:  hit = edgeOk;
        CMB_OR:    hit = matchHit[i] | edgeOk;
        default:   hit = matchHit[i] & edgeOk;
      endcase
      evFire[i]  = run & evCfg[i].stateMask[state] & hit;
      halfSel[i] = evCfg[i].halfSel;
    end
  end

  // strobes to datapath and state selection
  always_comb begin
    strobe         = '0;
    strobe.countEn = run;
    strobe.split   = split;
    goAny          = 1'b0;
    goTarget       = state;
    for (int i = NUM_EV - 1; i >= 0; i--) begin
      if (evFire[i] && evCfg[i].limit) begin
        if (!split || !evCfg[i].halfSel) strobe.limitLo = 1'b1;
        if (!split || evCfg[i].halfSel)  strobe.limitHi = 1'b1;
      end
      for (int c = 0; c < NUM_CAP; c++) begin
        if (evFire[i] && evCfg[i].capEn && evCfg[i].capSel == 2'(c)) strobe.capLoad[c] = 1'b1;
      end
      if (evFire[i] && evCfg[i].goEn) begin
        goAny    = 1'b1;
        goTarget = evCfg[i].goState;
      end
    end
  end

  // output resolution
  always_comb begin
    for (int o = 0; o < NUM_OUT; o++) begin
      setHit[o] = |(setMask[o] & evFire);
      clrHit[o] = |(clrMask[o] & evFire);
      outNext[o] = outPins[o];
      if (setHit[o] && clrHit[o]) begin
        unique case (confl[o])
          CF_HOLD:  outNext[o] = outPins[o];
          CF_SET:   outNext[o] = 1'b1;
          CF_CLEAR: outNext[o] = 1'b0;
          default:  outNext[o] = ~outPins[o];
        endcase
      end else if (setHit[o]) begin
        outNext[o] = 1'b1;
      end else if (clrHit[o]) begin
        outNext[o] = 1'b0;
      end
    end
  end

  assign flagClr = (regWe && regAddr == A_FLAGS) ? regWdata[NUM_EV-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= 1'b0;
      flags   <= '0;
      inPrev  <= '0;
      outPins <= '0;
    end else begin
      if (goAny) state <= goTarget;
      else if (regWe && regAddr == A_STATE) state <= regWdata[0];
      flags   <= (flags & ~flagClr) | evFire;
      inPrev  <= inPins;
      outPins <= outNext;
    end
  end

  // read-back
  always_comb begin
    regRdata = '0;
    if (regAddr == A_CTRL)  regRdata[1:0] = {split, run};
    if (regAddr == A_STATE) regRdata[0] = state;
    if (regAddr == A_FLAGS) regRdata[NUM_EV-1:0] = flags;
    if (regAddr == A_COUNT) regRdata[CNT_W-1:0] = cntVal;
    for (int i = 0; i < NUM_EV; i++) begin
      if (regAddr == A_MATCH + ADDR_W'(i)) regRdata[CNT_W-1:0] = matchVal[i];
      if (regAddr == A_EVCFG + ADDR_W'(i)) regRdata[14:0] = evCfg[i];
    end
    for (int o = 0; o < NUM_OUT; o++) begin
      if (regAddr == A_OUTCFG + ADDR_W'(o)) begin
        regRdata[NUM_EV-1:0]  = setMask[o];
        regRdata[8 +: NUM_EV] = clrMask[o];
        regRdata[17:16]       = confl[o];
      end
    end
    for (int c = 0; c < NUM_CAP; c++) begin
      if (regAddr == A_CAP + ADDR_W'(c)) regRdata[CNT_W-1:0] = capVal[c];
    end
  end
endmodule

// File: rtl/evt_state_timer.sv
module evt_state_timer
  import sct_pkg::*;
#(
  parameter int NUM_EV  = 4,
  parameter int NUM_OUT = 2,
  parameter int NUM_CAP = 2,
  parameter int NUM_IN  = 2,
  parameter int CNT_W   = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  input  logic [NUM_IN-1:0]  timerIn,
  output logic [NUM_OUT-1:0] timerOut
);
  strobe_t           strobe;
  logic [NUM_EV-1:0] matchHit, evFire, halfSel;
  logic [CNT_W-1:0]  cntVal;
  logic [CNT_W-1:0]  capVal [NUM_CAP];
  logic [CNT_W-1:0]  matchVal [NUM_EV];

  sct_control #(
    .NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT), .NUM_CAP(NUM_CAP),
    .NUM_IN(NUM_IN), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .inPins(timerIn),
    .matchHit(matchHit), .cntVal(cntVal), .capVal(capVal),
    .matchVal(matchVal), .halfSel(halfSel), .strobe(strobe),
    .evFire(evFire), .outPins(timerOut)
  );

  sct_datapath #(
    .NUM_EV(NUM_EV), .NUM_CAP(NUM_CAP), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .matchVal(matchVal),
    .halfSel(halfSel), .matchHit(matchHit), .cntVal(cntVal), .capVal(capVal)
  );
endmodule

// File: rtl/evt_state_timer_chk.sv
module evt_state_timer_chk
  import sct_pkg::*;
#(
  parameter int NUM_EV  = 4,
  parameter int NUM_OUT = 2,
  parameter int NUM_CAP = 2,
  parameter int CNT_W   = 32
) (
  input logic               clk,
  input logic               rstN,
  input strobe_t            strobe,
  input logic [CNT_W-1:0]   cntVal,
  input logic [CNT_W-1:0]   capVal [NUM_CAP],
  input logic [NUM_EV-1:0]  evFire,
  input logic [NUM_OUT-1:0] outPins
);
  localparam int HALF_W = CNT_W / 2;

  a_r3_limit_lo: assert property (@(posedge clk) disable iff (!rstN)
    strobe.limitLo |=> cntVal[HALF_W-1:0] == '0);

  a_r3_limit_hi: assert property (@(posedge clk) disable iff (!rstN)
    strobe.limitHi |=> cntVal[CNT_W-1:HALF_W] == '0);

  a_r2_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.countEn && !strobe.limitLo && !strobe.limitHi) |=> $stable(cntVal));

  a_r4_out_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (evFire == '0) |=> $stable(outPins));

  for (genvar c = 0; c < NUM_CAP; c++) begin : g_capchk
    a_r8_capture: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capLoad[c] |=> capVal[c] == $past(cntVal));
  end
endmodule

bind evt_state_timer evt_state_timer_chk #(
  .NUM_EV(NUM_EV), .NUM_OUT(NUM_OUT), .NUM_CAP(NUM_CAP), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rstN(rstN), .strobe(strobe), .cntVal(cntVal),
  .capVal(capVal), .evFire(evFire), .outPins(timerOut)
);

// File: tb/evt_state_timer_bench.sv
`timescale 1ns/1ps
module evt_state_timer_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [4:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [1:0]  timerIn = '0;
  logic [1:0]  timerOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // conflict table: {mode[3:2], out after first hit, out after second hit}
  localparam logic [3:0] CONF_TAB [4] = '{
    {2'd1, 1'b1, 1'b1},
    {2'd0, 1'b1, 1'b1},
    {2'd3, 1'b0, 1'b1},
    {2'd2, 1'b0, 1'b0}
  };

  always #2 clk = ~clk;

  evt_state_timer u_evt_state_timer (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .timerIn(timerIn), .timerOut(timerOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    regAddr = a;
    #0.1;
    d = regRdata;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; regWe = 1'b0; timerIn = '0;
    step(2);
    rstN = 1'b1;
    step(1);
  endtask

  task automatic waitCnt(input logic [31:0] v, input string req);
    logic [31:0] d;
    bit found = 1'b0;
    for (int k = 0; k < 2000; k++) begin
      rd(5'h03, d);
      if (d == v) begin found = 1'b1; break; end
      step(1);
    end
    if (!found) chk(req, 32'hDEAD, v);
  endtask

  task automatic pulse(input int idx);
    timerIn[idx] = 1'b1;
    step(1);
    timerIn[idx] = 1'b0;
    step(1);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, v;

    // R1 reset state
    doReset();
    rd(5'h03, d); chk("R1 count", d, 0);
    rd(5'h01, d); chk("R1 state", d, 0);
    rd(5'h02, d); chk("R1 flags", d, 0);
    rd(5'h14, d); chk("R1 cap0", d, 0);
    chk("R1 outputs", 32'(timerOut), 0);

    // conflict resolution table, R5
    wr(5'h0A, 32'h0000_0007);          // ev2: both states, input edge only, pin0 rising
    wr(5'h00, 32'h1);
    for (int r = 0; r < 4; r++) begin
      wr(5'h11, {14'b0, CONF_TAB[r][3:2], 16'h0404});
      pulse(0);
      chk("R5 first hit", 32'(timerOut[1]), 32'(CONF_TAB[r][1]));
      pulse(0);
      chk("R5 second hit", 32'(timerOut[1]), 32'(CONF_TAB[r][0]));
    end

    // R3 / R4 / R10 / R2: period of ten counts with set at limit, clear at 4
    doReset();
    wr(5'h04, 32'd9);
    wr(5'h08, 32'h0000_0103);
    wr(5'h05, 32'd4);
    wr(5'h09, 32'h0000_0003);
    wr(5'h10, 32'h0000_0201);
    wr(5'h00, 32'h1);
    waitCnt(32'd9, "R3 reach");
    chk("R4 before set", 32'(timerOut[0]), 0);
    step(1);
    rd(5'h03, d); chk("R3 limit restart", d, 0);
    chk("R4 set", 32'(timerOut[0]), 1);
    waitCnt(32'd4, "R4 reach");
    chk("R4 still set", 32'(timerOut[0]), 1);
    step(1);
    chk("R4 clear", 32'(timerOut[0]), 0);
    rd(5'h03, d); chk("R2 counting", d, 5);
    rd(5'h02, d); chk("R10 flags set", d, 32'h3);
    wr(5'h02, 32'h1);
    rd(5'h02, d); chk("R10 w1c", d, 32'h2);
    wr(5'h00, 32'h0);
    rd(5'h03, v);
    step(3);
    rd(5'h03, d); chk("R2 hold", d, v);

    // R1 reset during activity
    @(negedge clk);
    rstN = 1'b0;
    #0.2;
    rd(5'h03, d); chk("R1 async count", d, 0);
    rd(5'h02, d); chk("R1 async flags", d, 0);
    step(1);
    rstN = 1'b1;

    // R6 / R11: AND with level, falling edge with OR
    doReset();
    wr(5'h04, 32'd6);
    wr(5'h08, 32'h0000_00CF);          // ev0: AND, pin0 high level
    wr(5'h05, 32'd4);
    wr(5'h09, 32'h0000_00DF);          // ev1: AND, pin1 high level
    wr(5'h06, 32'hFFFF_0000);
    wr(5'h0A, 32'h0000_005B);          // ev2: OR, pin1 falling
    wr(5'h00, 32'h1);
    waitCnt(32'd2, "R6 reach");
    timerIn[0] = 1'b1;
    step(1);
    timerIn[0] = 1'b0;
    rd(5'h02, d); chk("R6 input without match", d, 0);
    waitCnt(32'd6, "R6 reach2");
    timerIn[0] = 1'b1;
    step(1);
    timerIn[0] = 1'b0;
    rd(5'h02, d); chk("R6 both true", d, 32'h1);
    timerIn[1] = 1'b1;
    step(1);
    rd(5'h02, d); chk("R11 rise ignored by fall test", d, 32'h1);
    timerIn[1] = 1'b0;
    step(1);
    rd(5'h02, d); chk("R11 falling fires", d, 32'h5);

    // R7 state machine
    doReset();
    wr(5'h08, 32'h0000_0605);          // ev0: state0 only, pin0 rise, go to 1
    wr(5'h09, 32'h0000_0206);          // ev1: state1 only, pin0 rise, go to 0
    wr(5'h10, 32'h0000_0201);
    wr(5'h00, 32'h1);
    pulse(0);
    rd(5'h01, d); chk("R7 to state1", d, 1);
    chk("R7 out set", 32'(timerOut[0]), 1);
    rd(5'h02, d); chk("R7 mask blocks ev1", d, 32'h1);
    pulse(0);
    rd(5'h01, d); chk("R7 to state0", d, 0);
    chk("R7 out clear", 32'(timerOut[0]), 0);
    rd(5'h02, d); chk("R7 ev1 in state1", d, 32'h3);

    // R8 capture
    doReset();
    wr(5'h0B, 32'h0000_1817);          // ev3: pin1 rise, capture into reg 1
    wr(5'h00, 32'h1);
    step(7);
    rd(5'h03, v);
    timerIn[1] = 1'b1;
    step(1);
    timerIn[1] = 1'b0;
    step(3);
    rd(5'h15, d); chk("R8 captured count", d, v);
    rd(5'h14, d); chk("R8 other reg untouched", d, 0);

    // R9 split halves
    doReset();
    wr(5'h04, 32'd3);
    wr(5'h08, 32'h0000_0103);          // ev0: low half limit at 3
    wr(5'h05, 32'd5);
    wr(5'h09, 32'h0000_4003);          // ev1: high half match 5
    wr(5'h10, 32'h0000_0002);
    wr(5'h00, 32'h3);
    waitCnt(32'h0003_0003, "R9 reach");
    step(1);
    rd(5'h03, d); chk("R9 low restarts high runs", d, 32'h0004_0000);
    step(1);
    rd(5'h03, d); chk("R9 halves", d, 32'h0005_0001);
    chk("R9 before high match", 32'(timerOut[0]), 0);
    step(1);
    chk("R9 high half match", 32'(timerOut[0]), 1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule